// File: doc/BRIEF.md
# Programmable Countdown Interrupt Timer

This block is a per-core countdown timer that raises an interrupt request when its counter runs out. Software programs it through a word-wide register port in which each register has an index. There are four registers: a control word (vector, mask, mode and a read-only pending flag), a start value, a read-only live count and a divider select. A free-running prescaler divides the clock by one or by a power of two from 2 to 128. The counter steps down once per prescaler tick.

Writing a nonzero start value loads the counter and starts it. Writing zero stops it. When the counter steps from one to zero with the mask clear, the block pulses an interrupt request for one cycle, with the programmed vector beside it. The pending flag stays set until the core acknowledges. The counter then either stops (single-shot) or reloads and runs again (repeating). A third mode value, intended for a timestamp comparison, is kept only as an inert placeholder: in that mode, and for the spare fourth value, the counter never moves.

Top module: `cdt_timer`

## Requirements
- R1: After reset the control word reads 0x0001_0000 (mask set, mode 0, vector 0, not pending), the start value, live count and divider select read 0, and `irq_req` is low.
- R2: Register indices on `addr` are: control 0x32, start value 0x38, live count 0x39, divider select 0x3E. Control bits [7:0] are the vector, bit 12 is the pending flag (writes to it have no effect), bit 16 is the mask and bits [18:17] are the mode. All other control bits read 0. An unmapped index reads 0, and writing to it changes no register.
- R3: Divider select values 0, 1, 2 and 3 divide by 2, 4, 8 and 16. Values 8, 9 and 10 divide by 32, 64 and 128, and 11 divides by 1. Bit 2 is ignored and reads back as 0, as do bits above 3. With division d and start value N, the request appears between (N-1)·d+1 and N·d cycles after the write edge.
- R4: Writing a nonzero start value sets the live count to that value on the write edge. At division 1 the live count then drops by one every cycle, so the start value minus a later reading gives the elapsed cycles.
- R5: Writing zero to the start value sets the live count to 0 and stops the counter. No request follows.
- R6: Mode 0 (single-shot): the counter reaches zero once and stays there. `irq_req` is high for exactly one cycle, in the cycle after the live count becomes 0, with `irq_vector` equal to control bits [7:0].
- R7: Mode 1 (repeating): on the cycle after the live count reaches zero it reloads the start value and keeps counting. At division 1 the requests are N+1 cycles apart.
- R8: With the mask set, expiry raises no request, but the live count still counts down to zero.
- R9: A request sets the pending flag (control bit 12). The flag clears on the cycle after `irq_ack` is high, unless a new request is issued on that same edge.
- R10: In mode 2 or 3 the live count holds its value, writes to the start value are ignored, and the start value reads 0. Returning to mode 0 resumes counting from the held value, and the start value written before reads back again.
- R11: A write to the divider select does not reload the live count. The new division applies from the next tick of the old division.
- R12: The counter is CNT_W bits wide. A start value write keeps only bits [CNT_W-1:0], and the zero/nonzero decision uses those bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register index for reads and writes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_ack | input | 1 | Acknowledge, clears the pending flag |
| irq_req | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Programmed interrupt vector |

## Verification
The bench builds the timer with CNT_W = 16. A start value above 16 bits then shows truncation, and a zero in the low half of such a value is a stop. It sweeps all sixteen divider-select values with a short start value. Each measured latency must fall in the window for its division, so every division, and the ignored bit 2, is separated from its neighbours. With division 1 the bench can predict every cycle exactly. At that setting it checks all four mode values, elapsed-tick readings, the repeat period, masking, the pending flag, the hold in the placeholder modes, and a divider change in the middle of a count.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

  localparam int ADDR_DEF_W = 8;
  localparam int PRE_W      = 7;

  localparam logic [ADDR_DEF_W-1:0] IDX_CTRL = 8'h32;
  localparam logic [ADDR_DEF_W-1:0] IDX_INIT = 8'h38;
  localparam logic [ADDR_DEF_W-1:0] IDX_CUR  = 8'h39;
  localparam logic [ADDR_DEF_W-1:0] IDX_DIV  = 8'h3E;

  typedef enum logic [1:0] {
    MODE_ONESHOT  = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_DEADLINE = 2'd2,
    MODE_SPARE    = 2'd3
  } tmode_e;

  // Divider select -> log2 of the division ratio
  function automatic logic [2:0] div_shift(input logic [3:0] sel);
    if (sel[3]) begin
      if (sel[1:0] == 2'b11) return 3'd0;
      return 3'd5 + {1'b0, sel[1:0]};
    end
    return 3'd1 + {1'b0, sel[1:0]};
  endfunction

  function automatic logic mode_counts(input tmode_e m);
    return (m == MODE_ONESHOT) || (m == MODE_PERIODIC);
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [7:0] vec, input logic pend,
                                            input logic msk, input tmode_e m);
    return {13'd0, m, msk, 3'd0, pend, 4'd0, vec};
  endfunction

endpackage

// File: rtl/cdt_prescale.sv
module cdt_prescale
  import cdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_shift,
  output logic       tick
);
  logic [PRE_W-1:0] phase;
  logic [2:0]       shift_act;
  logic [PRE_W-1:0] lane_mask;

  always_comb begin
    lane_mask = '0;
    for (int i = 0; i < PRE_W; i++) begin
      if (i < int'(shift_act)) lane_mask[i] = 1'b1;
    end
  end

  assign tick = ((phase & lane_mask) == lane_mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= '0;
      shift_act <= div_shift(4'd0);
    end else begin
      phase <= phase + 1'b1;
      if (tick) shift_act <= cfg_shift;
    end
  end
endmodule

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             count_en,
  input  logic             periodic,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cur,
  output logic             hit_zero
);
  logic running;
  logic reload_pend;

  assign hit_zero = !ld && count_en && running && !reload_pend && tick &&
                    (cur == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur         <= '0;
      running     <= 1'b0;
      reload_pend <= 1'b0;
    end else if (ld) begin
      cur         <= ld_val;
      running     <= (ld_val != '0);
      reload_pend <= 1'b0;
    end else if (count_en && reload_pend) begin
      cur         <= reload_val;
      reload_pend <= 1'b0;
    end else if (hit_zero) begin
      cur <= '0;
      if (periodic) reload_pend <= 1'b1;
      else          running     <= 1'b0;
    end else if (count_en && running && tick) begin
      cur <= cur - CNT_W'(1);
    end
  end
endmodule

// File: rtl/cdt_regs.sv
module cdt_regs
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [CNT_W-1:0]  cur,
  input  logic              irq_issue,
  input  logic              irq_ack,
  output logic [7:0]        vec,
  output logic              mask,
  output tmode_e            mode,
  output logic [3:0]        div_sel,
  output logic [CNT_W-1:0]  init_val,
  output logic              ld,
  output logic              pend,
  output logic [31:0]       rdata
);
  logic sel_ctrl, sel_init, sel_cur, sel_div;
  logic counts;

  assign sel_ctrl = (addr == ADDR_W'(IDX_CTRL));
  assign sel_init = (addr == ADDR_W'(IDX_INIT));
  assign sel_cur  = (addr == ADDR_W'(IDX_CUR));
  assign sel_div  = (addr == ADDR_W'(IDX_DIV));
  assign counts   = mode_counts(mode);
  assign ld       = wr_en && sel_init && counts;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec      <= '0;
      mask     <= 1'b1;
      mode     <= MODE_ONESHOT;
      div_sel  <= '0;
      init_val <= '0;
      pend     <= 1'b0;
    end else begin
      if (wr_en && sel_ctrl) begin
        vec  <= wdata[7:0];
        mask <= wdata[16];
        mode <= tmode_e'(wdata[18:17]);
      end
      if (wr_en && sel_div) div_sel <= {wdata[3], 1'b0, wdata[1:0]};
      if (ld) init_val <= wdata[CNT_W-1:0];
      if (irq_issue)    pend <= 1'b1;
      else if (irq_ack) pend <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (sel_ctrl)      rdata = ctrl_word(vec, pend, mask, mode);
    else if (sel_init) rdata = counts ? 32'(init_val) : 32'd0;
    else if (sel_cur)  rdata = 32'(cur);
    else if (sel_div)  rdata = 32'(div_sel);
  end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = ADDR_DEF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              irq_ack,
  output logic              irq_req,
  output logic [7:0]        irq_vector
);
  logic [7:0]       vec;
  logic             mask;
  tmode_e           mode;
  logic [3:0]       div_sel;
  logic [CNT_W-1:0] init_val;
  logic [CNT_W-1:0] cur;
  logic             ld, pend, tick, hit_zero, irq_issue, count_en;

  assign count_en   = mode_counts(mode);
  assign irq_issue  = hit_zero && !mask;
  assign irq_vector = vec;

  cdt_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cur(cur), .irq_issue(irq_issue), .irq_ack(irq_ack),
    .vec(vec), .mask(mask), .mode(mode), .div_sel(div_sel),
    .init_val(init_val), .ld(ld), .pend(pend), .rdata(rdata)
  );

  cdt_prescale u_pre (
    .clk(clk), .rst_n(rst_n), .cfg_shift(div_shift(div_sel)), .tick(tick)
  );

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .count_en(count_en),
    .periodic(mode == MODE_PERIODIC), .ld(ld), .ld_val(wdata[CNT_W-1:0]),
    .reload_val(init_val), .cur(cur), .hit_zero(hit_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= irq_issue;
  end
endmodule

// File: rtl/cdt_checker.sv
module cdt_checker
  import cdt_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [CNT_W-1:0]  wval,
  input logic              ld,
  input logic              hit_zero,
  input logic              count_en,
  input logic              mask,
  input logic              pend,
  input logic              irq_req,
  input logic [CNT_W-1:0]  cur
);
  assert_pulse_once_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |=> !irq_req);

  assert_pulse_at_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (cur == '0));

  assert_zero_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(IDX_INIT) && wval == '0 && count_en) |=> (cur == '0));

  assert_stub_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !count_en |=> $stable(cur));

  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_zero && mask) |=> !irq_req);

  assert_pending_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> pend);

  assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count_en && !ld && cur > CNT_W'(1)) |=>
      (cur == $past(cur) || cur == $past(cur) - CNT_W'(1)));
endmodule

bind cdt_timer cdt_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wval(wdata[CNT_W-1:0]),
  .ld(ld), .hit_zero(hit_zero), .count_en(count_en), .mask(mask), .pend(pend),
  .irq_req(irq_req), .cur(cur)
);

// File: tb/cdt_timer_tb.sv
module cdt_timer_tb;
  localparam int CW = 16;
  localparam logic [7:0] A_CTRL = 8'h32, A_INIT = 8'h38, A_CUR = 8'h39, A_DIV = 8'h3E;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq_ack = 1'b0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic irq_req;
  logic [7:0] irq_vector;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  cdt_timer #(.CNT_W(CW), .ADDR_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vector(irq_vector)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic check_range(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_irq(output int n, input int limit);
    n = 0;
    while (!irq_req && n < limit) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, c1;
    int n, pulses, first;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, v); check("R1 ctrl", v, 32'h0001_0000);
    rd(A_INIT, v); check("R1 init", v, 0);
    rd(A_CUR, v);  check("R1 cur", v, 0);
    rd(A_DIV, v);  check("R1 div", v, 0);
    check("R1 irq", {31'd0, irq_req}, 0);

    // R2 layout, reserved bits, unmapped index
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, v); check("R2 ctrl reserved", v, 32'h0007_00FF);
    wr(8'h33, 32'h0);
    rd(A_CTRL, v); check("R2 unmapped write", v, 32'h0007_00FF);
    rd(8'h33, v);  check("R2 unmapped read", v, 0);
    wr(A_CTRL, 32'h0000_0040);

    // R3 divider sweep
    for (int code = 0; code < 16; code++) begin
      int sh, d;
      sh = code[3] ? (((code & 3) == 3) ? 0 : 5 + (code & 3)) : 1 + (code & 3);
      d = 1 << sh;
      wr(A_DIV, code);
      rd(A_DIV, v); check("R3 div readback", v, code & 32'hB);
      repeat (300) @(negedge clk);
      wr(A_INIT, 3);
      wait_irq(n, 2000);
      check_range("R3 latency", n, 2 * d + 1, 3 * d);
      rd(A_CUR, v); check("R3 cur at expiry", v, 0);
      wr(A_INIT, 0);
    end

    wr(A_DIV, 32'hB);
    repeat (300) @(negedge clk);

    // R6 R7 R10 mode sweep
    for (int m = 0; m < 4; m++) begin
      wr(A_INIT, 0);
      wr(A_CTRL, (m << 17) | (8'h30 + m));
      wr(A_INIT, 4);
      pulses = 0; first = -1;
      for (int k = 1; k <= 30; k++) begin
        @(negedge clk);
        if (irq_req) begin
          if (first < 0) begin
            first = k;
            check("R6 vector", irq_vector, 8'h30 + m);
          end
          pulses++;
        end
      end
      if (m == 0) begin
        check("R6 single pulse", pulses, 1);
        check("R6 first at N", first, 4);
        rd(A_CUR, v); check("R6 stays zero", v, 0);
      end else if (m == 1) begin
        check("R7 pulse count", pulses, 6);
        check("R7 first at N", first, 4);
        rd(A_CUR, v); check("R7 reloaded", v, 4);
      end else begin
        check("R10 no pulse", pulses, 0);
        rd(A_CUR, v); check("R10 no count", v, 0);
        rd(A_INIT, v); check("R10 init reads 0", v, 0);
      end
    end

    // R9 pending flag
    wr(A_CTRL, 32'h40);
    rd(A_CTRL, v); check("R9 pending", v, 32'h0000_1040);
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
    rd(A_CTRL, v); check("R9 cleared", v, 32'h0000_0040);

    // R4 elapsed measurement
    wr(A_INIT, 1000);
    rd(A_CUR, v); check("R4 load", v, 1000);
    repeat (37) @(negedge clk);
    rd(A_CUR, v); check("R4 elapsed", v, 963);

    // R5 stop
    wr(A_INIT, 0);
    rd(A_CUR, v); check("R5 cur zero", v, 0);
    wait_irq(n, 200); check("R5 no irq", n, 200);

    // R8 masked
    wr(A_CTRL, 32'h0001_0040);
    wr(A_INIT, 4);
    @(negedge clk); @(negedge clk);
    rd(A_CUR, v); check("R8 still counts", v, 2);
    wait_irq(n, 20); check("R8 no irq", n, 20);
    rd(A_CUR, v); check("R8 reached zero", v, 0);

    // R10 freeze and resume
    wr(A_CTRL, 32'h40);
    wr(A_INIT, 9);
    @(negedge clk); @(negedge clk);
    wr(A_CTRL, 32'h0004_0040);
    rd(A_CUR, v); c1 = v;
    check("R10 freeze point", c1, 6);
    wr(A_INIT, 32'h55);
    repeat (10) @(negedge clk);
    rd(A_CUR, v); check("R10 held", v, 6);
    wr(A_CTRL, 32'h40);
    rd(A_INIT, v); check("R10 init kept", v, 9);
    repeat (3) @(negedge clk);
    rd(A_CUR, v); check("R10 resumed", v, 3);
    wr(A_INIT, 0);

    // R11 divider change mid-count
    wr(A_DIV, 32'hA);
    repeat (300) @(negedge clk);
    wr(A_INIT, 1000);
    repeat (300) @(negedge clk);
    rd(A_CUR, v); c1 = v;
    check_range("R11 slow count", int'(c1), 996, 998);
    wr(A_DIV, 32'hB);
    rd(A_CUR, v); check_range("R11 no reload", int'(v), int'(c1) - 1, int'(c1));
    repeat (200) @(negedge clk);
    rd(A_CUR, v); check_range("R11 new rate", int'(v), int'(c1) - 201, int'(c1) - 72);
    wr(A_INIT, 0);

    // R12 truncation
    wr(A_INIT, 32'h0001_0005);
    rd(A_CUR, v); check("R12 truncated load", v, 5);
    wr(A_INIT, 0);
    wr(A_INIT, 32'h0003_0000);
    rd(A_CUR, v); check("R12 low zero stops", v, 0);
    wait_irq(n, 50); check("R12 no irq", n, 50);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule